// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block drives the command protocol of a standard parallel NOR flash so that software does not have to. A requester picks one of four operations (single-word program, buffered multi-word program, sector erase, chip erase) and supplies a target word address, a sector word address and, for buffered programming, a word count. The data words come from a small local buffer that is loaded beforehand through its own write port. Once accepted, the sequencer issues the unlock cycles, the command cycles and the data cycles one at a time through a simple request/acknowledge bus-write port.

After the final command write, the sequencer reads device status over and over. It stops when bit 6 returns the same value on two consecutive reads. A poll limit bounds the wait. The block reports busy while it works, and gives a one-cycle pulse for completion, for a timeout, for acceptance and for refusal of a request.

Top module: `nor_cmd_seq`

## Requirements
- R1: Operation code 0 (single word) issues four writes in order: 0xAA at word 0x555, 0x55 at word 0x2AA, 0xA0 at word 0x555, then buffer entry 0 at the program address.
- R2: Operation code 1 (buffered) issues 0xAA at 0x555 and 0x55 at 0x2AA. Next it writes 0x25 to the sector address and then the word count minus one to the sector address. The N buffer entries 0..N-1 follow at program address + 0..N-1. The last write is 0x29 to the sector address.
- R3: Operation code 2 (sector erase) issues 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA, 0x30@sector address.
- R4: Operation code 3 (chip erase) issues the same first five writes as R3, followed by 0x10 at 0x555.
- R5: With the 16-bit bus option set, every word address is driven on the byte address shifted left by one, so bit 0 is always 0.
- R6: Each bus transaction keeps request, direction, address and write data steady until acknowledged. Only one transaction is in flight, and the bus is quiet whenever the block is not busy.
- R7: After the final write, status reads go to the program address for codes 0 and 1, to the sector address for code 2 and to address 0 for code 3. Once bit 6 is equal in two consecutive reads, done pulses for one cycle and busy is low in that same cycle. Other status bits are ignored.
- R8: If the number of status reads reaches the poll limit without bit 6 settling, timeout pulses for one cycle, done stays low and the block returns to idle. A limit of 0 acts as 1. A settling read that is also the last allowed read counts as done.
- R9: A request made while busy is refused: reject pulses the next cycle and the running operation continues unchanged.
- R10: A buffered request with a count of 0 or a count greater than the buffer depth is refused with reject and produces no bus activity.
- R11: During and after reset, busy, done, timeout, accept, reject and the bus request are low.
- R12: A valid request made while idle gives an accept pulse in the next cycle, and busy is high from that cycle on.
- R13: Buffer writes made while busy are ignored. The operation in progress uses the data loaded before it started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Operation request strobe |
| req_op | input | 2 | Operation: 0 word, 1 buffered, 2 sector erase, 3 chip erase |
| req_addr | input | ADDR_W | Program word address |
| req_sector | input | ADDR_W | Sector word address |
| req_count | input | CNT_W | Word count for buffered programming |
| poll_limit | input | POLL_W | Maximum number of status reads |
| buf_wr_en | input | 1 | Data buffer write strobe |
| buf_wr_idx | input | IDX_W | Data buffer entry index |
| buf_wr_data | input | DATA_W | Data buffer write word |
| req_accept | output | 1 | One-cycle pulse: request taken |
| req_reject | output | 1 | One-cycle pulse: request refused |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: operation completed |
| timeout | output | 1 | One-cycle pulse: poll limit reached |
| bus_req | output | 1 | Bus transaction request |
| bus_we | output | 1 | 1 write, 0 status read |
| bus_addr | output | ADDR_W | Byte address on the bus |
| bus_wdata | output | DATA_W | Write data |
| bus_ack | input | 1 | Transaction completion acknowledge |
| bus_rdata | input | DATA_W | Read data, valid with bus_ack |

## Verification
The bench builds the sequencer with a buffer depth of 4, a 20-bit address, 16-bit data, an 8-bit poll limit and the 16-bit bus option. The small depth makes a full-buffer program and the first count beyond the buffer cheap to reach. The narrow limit keeps timeout runs short and lets a limit of exactly the settling read be tested. The bench acknowledges with latencies of 0 to 2 cycles. Its status model toggles bit 6 a chosen number of times and always flips an unrelated bit.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

  typedef enum logic [1:0] {
    OP_WORD = 2'd0,
    OP_BUF  = 2'd1,
    OP_SECT = 2'd2,
    OP_CHIP = 2'd3
  } nor_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMD  = 2'd1,
    ST_POLL = 2'd2
  } seq_state_e;

  localparam logic [11:0] UNLK_ADDR_A = 12'h555;
  localparam logic [11:0] UNLK_ADDR_B = 12'h2AA;

  localparam logic [7:0] CODE_KEY_A  = 8'hAA;
  localparam logic [7:0] CODE_KEY_B  = 8'h55;
  localparam logic [7:0] CODE_PROG   = 8'hA0;
  localparam logic [7:0] CODE_ERASE  = 8'h80;
  localparam logic [7:0] CODE_SECT   = 8'h30;
  localparam logic [7:0] CODE_CHIP   = 8'h10;
  localparam logic [7:0] CODE_LOAD   = 8'h25;
  localparam logic [7:0] CODE_CONF   = 8'h29;

  localparam int TOGGLE_BIT = 6;

endpackage

// File: rtl/nor_seq_buf.sv
module nor_seq_buf #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    logic hit;
    assign hit = wr_en && ({1'b0, wr_idx} == (IDX_W+1)'(e));
    always_ff @(posedge clk) begin
      if (hit) begin
        mem_q[e] <= wr_data;
      end
    end
  end

  always_comb begin
    if ({1'b0, rd_idx} < (IDX_W+1)'(DEPTH)) begin
      rd_data = mem_q[rd_idx];
    end else begin
      rd_data = '0;
    end
  end

endmodule

// File: rtl/nor_seq_script.sv
module nor_seq_script
  import nor_seq_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter int STEP_W = 5,
  parameter int CNT_W  = 5,
  parameter int IDX_W  = 4
) (
  input  nor_op_e           op,
  input  logic [STEP_W-1:0] step,
  input  logic [CNT_W-1:0]  count,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic [ADDR_W-1:0] sect_addr,
  input  logic [DATA_W-1:0] buf_data,
  output logic [IDX_W-1:0]  buf_idx,
  output logic [ADDR_W-1:0] cyc_addr,
  output logic [DATA_W-1:0] cyc_data,
  output logic              cyc_last
);

  localparam logic [STEP_W-1:0] S0 = STEP_W'(0);
  localparam logic [STEP_W-1:0] S1 = STEP_W'(1);
  localparam logic [STEP_W-1:0] S2 = STEP_W'(2);
  localparam logic [STEP_W-1:0] S3 = STEP_W'(3);
  localparam logic [STEP_W-1:0] S4 = STEP_W'(4);
  localparam logic [STEP_W-1:0] S5 = STEP_W'(5);

  localparam logic [ADDR_W-1:0] WA_A = ADDR_W'(UNLK_ADDR_A);
  localparam logic [ADDR_W-1:0] WA_B = ADDR_W'(UNLK_ADDR_B);

  logic [STEP_W-1:0] data_off;
  logic [STEP_W:0]   conf_step;

  assign data_off  = step - S4;
  assign conf_step = (STEP_W+1)'(count) + (STEP_W+1)'(4);

  always_comb begin
    cyc_addr = WA_A;
    cyc_data = DATA_W'(CODE_KEY_A);
    cyc_last = 1'b0;
    buf_idx  = '0;
    if (step == S1) begin
      cyc_addr = WA_B;
      cyc_data = DATA_W'(CODE_KEY_B);
    end else if (step != S0) begin
      unique case (op)
        OP_WORD: begin
          if (step == S2) begin
            cyc_data = DATA_W'(CODE_PROG);
          end else begin
            cyc_addr = prog_addr;
            cyc_data = buf_data;
            cyc_last = 1'b1;
          end
        end
        OP_BUF: begin
          if (step == S2) begin
            cyc_addr = sect_addr;
            cyc_data = DATA_W'(CODE_LOAD);
          end else if (step == S3) begin
            cyc_addr = sect_addr;
            cyc_data = DATA_W'(count - CNT_W'(1));
          end else if ({1'b0, step} < conf_step) begin
            buf_idx  = data_off[IDX_W-1:0];
            cyc_addr = prog_addr + ADDR_W'(data_off);
            cyc_data = buf_data;
          end else begin
            cyc_addr = sect_addr;
            cyc_data = DATA_W'(CODE_CONF);
            cyc_last = 1'b1;
          end
        end
        default: begin
          if (step == S2) begin
            cyc_data = DATA_W'(CODE_ERASE);
          end else if (step == S3) begin
            cyc_data = DATA_W'(CODE_KEY_A);
          end else if (step == S4) begin
            cyc_addr = WA_B;
            cyc_data = DATA_W'(CODE_KEY_B);
          end else begin
            cyc_last = (step == S5);
            if (op == OP_SECT) begin
              cyc_addr = sect_addr;
              cyc_data = DATA_W'(CODE_SECT);
            end else begin
              cyc_data = DATA_W'(CODE_CHIP);
            end
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/nor_seq_poll.sv
module nor_seq_poll
  import nor_seq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int POLL_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              active,
  input  logic              rd_ack,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [POLL_W-1:0] limit,
  output logic              finished,
  output logic              expired
);

  logic              seen_q, seen_d;
  logic              prev_q, prev_d;
  logic [POLL_W-1:0] reads_q, reads_d;
  logic [POLL_W-1:0] eff_limit;
  logic              cur_bit;

  assign eff_limit = (limit == '0) ? POLL_W'(1) : limit;
  assign cur_bit   = rd_data[TOGGLE_BIT];
  assign finished  = rd_ack && seen_q && (cur_bit == prev_q);
  assign expired   = rd_ack && !finished &&
                     (({1'b0, reads_q} + (POLL_W+1)'(1)) >= {1'b0, eff_limit});

  always_comb begin
    seen_d  = seen_q;
    prev_d  = prev_q;
    reads_d = reads_q;
    if (start) begin
      seen_d  = 1'b0;
      prev_d  = 1'b0;
      reads_d = '0;
    end else if (rd_ack) begin
      seen_d  = 1'b1;
      prev_d  = cur_bit;
      reads_d = reads_q + POLL_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q  <= 1'b0;
      prev_q  <= 1'b0;
      reads_q <= '0;
    end else if (start || rd_ack) begin
      seen_q  <= seen_d;
      prev_q  <= prev_d;
      reads_q <= reads_d;
    end
  end

  AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (reads_q < eff_limit)) else $error("poll count past limit"); // R8

  AST_FIRST_READ_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (active && reads_q == '0) |-> !finished) else $error("settle on first read"); // R7

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_seq_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 16,
  parameter int BUF_DEPTH = 16,
  parameter int POLL_W    = 16,
  parameter bit BUS16     = 1'b1,
  localparam int CNT_W    = $clog2(BUF_DEPTH + 1),
  localparam int IDX_W    = $clog2(BUF_DEPTH),
  localparam int STEP_W   = $clog2(BUF_DEPTH + 6)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ADDR_W-1:0] req_sector,
  input  logic [CNT_W-1:0]  req_count,
  input  logic [POLL_W-1:0] poll_limit,
  input  logic              buf_wr_en,
  input  logic [IDX_W-1:0]  buf_wr_idx,
  input  logic [DATA_W-1:0] buf_wr_data,
  output logic              req_accept,
  output logic              req_reject,
  output logic              busy,
  output logic              done,
  output logic              timeout,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata
);

  seq_state_e        state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  nor_op_e           op_q;
  logic [ADDR_W-1:0] addr_q, sect_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [POLL_W-1:0] lim_q;
  logic              accept_q, reject_q, done_q, tout_q;
  logic              ev_done, ev_tout;

  logic              is_busy, count_bad, take, refuse;
  nor_op_e           in_op;

  logic [IDX_W-1:0]  rd_idx;
  logic [DATA_W-1:0] rd_word;
  logic [ADDR_W-1:0] cyc_addr, poll_addr, word_addr;
  logic [DATA_W-1:0] cyc_data;
  logic              cyc_last;
  logic              poll_fin, poll_exp, poll_ack;

  // request qualification
  assign in_op     = nor_op_e'(req_op);
  assign is_busy   = (state_q != ST_IDLE);
  assign count_bad = (in_op == OP_BUF) &&
                     ((req_count == '0) || (req_count > CNT_W'(BUF_DEPTH)));
  assign take      = req_valid && !is_busy && !count_bad;
  assign refuse    = req_valid && (is_busy || count_bad);

  nor_seq_buf #(
    .DATA_W (DATA_W),
    .DEPTH  (BUF_DEPTH)
  ) u_buf (
    .clk     (clk),
    .wr_en   (buf_wr_en && !is_busy),
    .wr_idx  (buf_wr_idx),
    .wr_data (buf_wr_data),
    .rd_idx  (rd_idx),
    .rd_data (rd_word)
  );

  nor_seq_script #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .STEP_W (STEP_W),
    .CNT_W  (CNT_W),
    .IDX_W  (IDX_W)
  ) u_script (
    .op        (op_q),
    .step      (step_q),
    .count     (cnt_q),
    .prog_addr (addr_q),
    .sect_addr (sect_q),
    .buf_data  (rd_word),
    .buf_idx   (rd_idx),
    .cyc_addr  (cyc_addr),
    .cyc_data  (cyc_data),
    .cyc_last  (cyc_last)
  );

  assign poll_ack = bus_ack && (state_q == ST_POLL);

  nor_seq_poll #(
    .DATA_W (DATA_W),
    .POLL_W (POLL_W)
  ) u_poll (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (take),
    .active   (state_q == ST_POLL),
    .rd_ack   (poll_ack),
    .rd_data  (bus_rdata),
    .limit    (lim_q),
    .finished (poll_fin),
    .expired  (poll_exp)
  );

  // status read location
  always_comb begin
    unique case (op_q)
      OP_SECT: poll_addr = sect_q;
      OP_CHIP: poll_addr = '0;
      default: poll_addr = addr_q;
    endcase
  end

  assign word_addr = (state_q == ST_CMD) ? cyc_addr : poll_addr;

  if (BUS16) begin : g_bus16
    assign bus_addr = {word_addr[ADDR_W-2:0], 1'b0};
  end else begin : g_bus8
    assign bus_addr = word_addr;
  end

  assign bus_req   = is_busy;
  assign bus_we    = (state_q == ST_CMD);
  assign bus_wdata = (state_q == ST_CMD) ? cyc_data : '0;

  // next state
  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    ev_done = 1'b0;
    ev_tout = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (take) begin
          state_d = ST_CMD;
          step_d  = '0;
        end
      end
      ST_CMD: begin
        if (bus_ack) begin
          if (cyc_last) begin
            state_d = ST_POLL;
          end else begin
            step_d = step_q + STEP_W'(1);
          end
        end
      end
      ST_POLL: begin
        if (poll_fin) begin
          state_d = ST_IDLE;
          ev_done = 1'b1;
        end else if (poll_exp) begin
          state_d = ST_IDLE;
          ev_tout = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_WORD;
      addr_q <= '0;
      sect_q <= '0;
      cnt_q  <= '0;
      lim_q  <= '0;
    end else if (take) begin
      op_q   <= in_op;
      addr_q <= req_addr;
      sect_q <= req_sector;
      cnt_q  <= req_count;
      lim_q  <= poll_limit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      accept_q <= 1'b0;
      reject_q <= 1'b0;
      done_q   <= 1'b0;
      tout_q   <= 1'b0;
    end else begin
      accept_q <= take;
      reject_q <= refuse;
      done_q   <= ev_done;
      tout_q   <= ev_tout;
    end
  end

  assign req_accept = accept_q;
  assign req_reject = reject_q;
  assign busy       = is_busy;
  assign done       = done_q;
  assign timeout    = tout_q;

  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_we) && $stable(bus_addr)
                               && $stable(bus_wdata))) else $error("bus changed before ack"); // R6

  AST_EVEN_BYTE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (BUS16 && bus_req) |-> !bus_addr[0]) else $error("odd byte address"); // R5

  AST_END_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && timeout)) else $error("done with timeout"); // R8

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (done || timeout) |-> (!busy && !bus_req)) else $error("end pulse while busy"); // R7

  AST_BUSY_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid) |=> (req_reject && !req_accept)) else $error("busy request not refused"); // R9

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    req_accept |-> busy) else $error("accept without busy"); // R12

  AST_PULSE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done longer than a cycle"); // R7

endmodule

// File: tb/nor_cmd_seq_test.sv
module nor_cmd_seq_test;

  localparam int AW = 20;
  localparam int DW = 16;
  localparam int DEPTH = 4;
  localparam int PW = 8;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid;
  logic [1:0] req_op;
  logic [AW-1:0] req_addr, req_sector;
  logic [CW-1:0] req_count;
  logic [PW-1:0] poll_limit;
  logic buf_wr_en;
  logic [IW-1:0] buf_wr_idx;
  logic [DW-1:0] buf_wr_data;
  logic req_accept, req_reject, busy, done, timeout;
  logic bus_req, bus_we, bus_ack;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;

  always #10 clk = ~clk;

  nor_cmd_seq #(.ADDR_W(AW), .DATA_W(DW), .BUF_DEPTH(DEPTH), .POLL_W(PW), .BUS16(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_sector(req_sector), .req_count(req_count),
    .poll_limit(poll_limit), .buf_wr_en(buf_wr_en), .buf_wr_idx(buf_wr_idx),
    .buf_wr_data(buf_wr_data), .req_accept(req_accept), .req_reject(req_reject),
    .busy(busy), .done(done), .timeout(timeout), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata));

  int checks = 0;
  int errors = 0;
  int lat = 0;
  int tog_k = 0;
  int rd_n = 0;
  logic [AW-1:0] exp_poll;
  string tag = "R11";
  logic [AW+DW-1:0] exp_q[$];

  function automatic logic [AW-1:0] sh(input logic [AW-1:0] w);
    return {w[AW-2:0], 1'b0};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(input logic [AW-1:0] wa, input logic [7:0] d8);
    exp_q.push_back({sh(wa), DW'(d8)});
  endtask

  task automatic push_w(input logic [AW-1:0] wa, input logic [DW-1:0] d);
    exp_q.push_back({sh(wa), d});
  endtask

  task automatic unlock();
    push(20'h555, 8'hAA);
    push(20'h2AA, 8'h55);
  endtask

  task automatic load(input int idx, input logic [DW-1:0] d);
    buf_wr_en = 1'b1; buf_wr_idx = IW'(idx); buf_wr_data = d;
    @(negedge clk);
    buf_wr_en = 1'b0;
  endtask

  // monitor: bus responder and scoreboard
  initial begin
    bus_ack = 1'b0;
    bus_rdata = '0;
    forever begin
      int wcnt;
      @(negedge clk);
      if (bus_ack) begin
        bus_ack = 1'b0;
      end else if (bus_req) begin
        if (wcnt < lat) begin
          wcnt++;
        end else begin
          wcnt = 0;
          if (bus_we) begin
            if (exp_q.size() == 0) begin
              chk(1'b0, {tag, " unexpected write"}, {bus_addr, bus_wdata}, 0);
            end else begin
              logic [AW+DW-1:0] e;
              e = exp_q.pop_front();
              chk({bus_addr, bus_wdata} == e, {tag, " write cycle"}, {bus_addr, bus_wdata}, e);
            end
            bus_rdata = '0;
          end else begin
            int s;
            chk(exp_q.size() == 0, {tag, " read before last write"}, exp_q.size(), 0);
            chk(bus_addr == exp_poll, {tag, " R7 poll address"}, bus_addr, exp_poll);
            s = (rd_n < tog_k) ? rd_n : tog_k;
            bus_rdata = '0;
            bus_rdata[6] = s[0];
            bus_rdata[2] = rd_n[0];
            bus_rdata[15] = ~rd_n[0];
            rd_n++;
          end
          bus_ack = 1'b1;
        end
      end
    end
  end

  task automatic start_op(input int op, input logic [AW-1:0] a, input logic [AW-1:0] s,
                          input int cnt, input int lim, input int k);
    tog_k = k;
    rd_n = 0;
    req_op = 2'(op); req_addr = a; req_sector = s; req_count = CW'(cnt);
    poll_limit = PW'(lim);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_accept == 1'b1 && req_reject == 1'b0, "R12 accept pulse", {req_accept, req_reject}, 2'b10);
    chk(busy == 1'b1, "R12 busy after accept", busy, 1);
  endtask

  task automatic wait_end(input bit exp_done, input int exp_reads);
    int n = 0;
    while (!(done || timeout) && n < 4000) begin
      @(negedge clk);
      n++;
    end
    chk(n < 4000, {tag, " completion watchdog"}, n, 4000);
    chk(done == exp_done && timeout == !exp_done, {tag, " outcome done/timeout"}, {done, timeout}, {exp_done, !exp_done});
    chk(busy == 1'b0 && bus_req == 1'b0, {tag, " R7 idle at end pulse"}, {busy, bus_req}, 0);
    chk(rd_n == exp_reads, {tag, " status read count"}, rd_n, exp_reads);
    chk(exp_q.size() == 0, {tag, " writes left over"}, exp_q.size(), 0);
    @(negedge clk);
    chk(done == 1'b0 && timeout == 1'b0, {tag, " end pulse one cycle"}, {done, timeout}, 0);
  endtask

  task automatic bad_req(input int cnt);
    req_op = 2'd1; req_count = CW'(cnt); req_addr = 20'h100; req_sector = 20'h100;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_reject == 1'b1 && req_accept == 1'b0 && busy == 1'b0, "R10 bad count refused",
        {req_reject, req_accept, busy}, 3'b100);
    repeat (3) @(negedge clk);
    chk(bus_req == 1'b0 && busy == 1'b0, "R10 no bus activity", {bus_req, busy}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_op = '0; req_addr = '0; req_sector = '0; req_count = '0;
    poll_limit = '0; buf_wr_en = 1'b0; buf_wr_idx = '0; buf_wr_data = '0;
    repeat (3) @(negedge clk);
    chk({busy, done, timeout, req_accept, req_reject, bus_req} == 0, "R11 in reset",
        {busy, done, timeout, req_accept, req_reject, bus_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, done, timeout, req_accept, req_reject, bus_req} == 0, "R11 after reset",
        {busy, done, timeout, req_accept, req_reject, bus_req}, 0);

    // R1 R5 R13 R9: word program; limit equals the settling read (R8 priority)
    tag = "R1";
    lat = 2;
    load(0, 16'hBEEF);
    unlock(); push(20'h555, 8'hA0); push_w(20'h01234, 16'hBEEF);
    exp_poll = sh(20'h01234);
    start_op(0, 20'h01234, 20'h01000, 0, 5, 3);
    req_op = 2'd2; req_valid = 1'b1;
    buf_wr_en = 1'b1; buf_wr_idx = '0; buf_wr_data = 16'h1111;
    @(negedge clk);
    req_valid = 1'b0; buf_wr_en = 1'b0;
    chk(req_reject == 1'b1 && req_accept == 1'b0, "R9 refused while busy", {req_reject, req_accept}, 2'b10);
    tag = "R1 R13 R8";
    wait_end(1'b1, 5);

    // R2: full buffer
    tag = "R2 full";
    lat = 0;
    load(0, 16'h0A01); load(1, 16'h0B02); load(2, 16'h0C03); load(3, 16'h0D04);
    unlock(); push(20'h0A000, 8'h25); push(20'h0A000, 8'h03);
    push_w(20'h0A010, 16'h0A01); push_w(20'h0A011, 16'h0B02);
    push_w(20'h0A012, 16'h0C03); push_w(20'h0A013, 16'h0D04);
    push(20'h0A000, 8'h29);
    exp_poll = sh(20'h0A010);
    start_op(1, 20'h0A010, 20'h0A000, 4, 10, 0);
    wait_end(1'b1, 2);

    // R2: single word through buffer
    tag = "R2 one";
    lat = 1;
    load(0, 16'h5A5A);
    unlock(); push(20'h3F000, 8'h25); push(20'h3F000, 8'h00);
    push_w(20'h3F7FF, 16'h5A5A); push(20'h3F000, 8'h29);
    exp_poll = sh(20'h3F7FF);
    start_op(1, 20'h3F7FF, 20'h3F000, 1, 10, 1);
    wait_end(1'b1, 3);

    // R3 sector erase
    tag = "R3";
    unlock(); push(20'h555, 8'h80); unlock(); push(20'h0A000, 8'h30);
    exp_poll = sh(20'h0A000);
    start_op(2, 20'h00055, 20'h0A000, 0, 20, 2);
    wait_end(1'b1, 4);

    // R4 chip erase
    tag = "R4";
    lat = 0;
    unlock(); push(20'h555, 8'h80); unlock(); push(20'h555, 8'h10);
    exp_poll = '0;
    start_op(3, 20'h12345, 20'h0A000, 0, 30, 4);
    wait_end(1'b1, 6);

    // R8 timeout
    tag = "R8 limit";
    lat = 1;
    unlock(); push(20'h555, 8'h80); unlock(); push(20'h02000, 8'h30);
    exp_poll = sh(20'h02000);
    start_op(2, 20'h0, 20'h02000, 0, 6, 1000);
    wait_end(1'b0, 6);

    tag = "R8 zero";
    unlock(); push(20'h555, 8'h80); unlock(); push(20'h555, 8'h10);
    exp_poll = '0;
    start_op(3, 20'h0, 20'h0, 0, 0, 1000);
    wait_end(1'b0, 1);

    // R10 counts out of range
    bad_req(0);
    bad_req(5);

    // recovery after refusals
    tag = "R1 again";
    lat = 0;
    load(0, 16'h7E81);
    unlock(); push(20'h555, 8'hA0); push_w(20'h00002, 16'h7E81);
    exp_poll = sh(20'h00002);
    start_op(0, 20'h00002, 20'h0, 0, 50, 2);
    wait_end(1'b1, 4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule